// File: doc/BRIEF.md
# Bus-Matching Width Converter for a 36-bit FIFO

This block sits between a 36-bit FIFO storage stream and the two external ports of the FIFO. On the write side it gathers narrow words of 18 or 9 bits into full 36-bit storage words. On the read side it splits 36-bit storage words back into narrow words. Each side has its own width setting: full (36), half (18) or quarter (9). Together they give the five legal pairings 36→36, 36→18, 36→9, 18→36 and 9→36. A byte-order input decides whether the most or the least significant sub-word travels first.

All three sides use a valid/ready handshake. The widths and the byte order are captured only while reset is applied and then stay fixed. The block reports how many 9-bit lanes it holds in a half-built write word and in a half-drained read word, so the FIFO flag logic can count them. A synchronous partial reset drops those partial words and keeps the configuration.

Top module: `bus_match_conv`

## Requirements
- R1: The width codes (0 = 36-bit, 1 = 18-bit, 2 = 9-bit, 3 = treated as 36-bit) and the byte-order bit (1 = big-endian) are captured while reset is asserted. Changes after reset release have no effect until the next reset.
- R2: With both sides at 36 bits, every write word reaches the storage side unchanged, and every storage word reaches the read side unchanged, one transfer each.
- R3: With an 18-bit or 9-bit write side, a storage write is offered only once 2 or 4 narrow words have been accepted. Lane k of a storage word occupies bits [9k+8:9k]: lane 3 = [35:27], lane 0 = [8:0]. A narrow word is taken from the low bits of wr_data.
- R4: With an 18-bit or 9-bit read side, each storage word yields 2 or 4 read words. Each read word sits in the low bits of rd_data, and all higher bits are zero.
- R5: In big-endian mode, the most significant sub-word of a storage word is transferred first on the narrow side.
- R6: In little-endian mode, the least significant sub-word is transferred first on the narrow side.
- R7: If both width codes select a narrow width, the read side is forced to 36 bits and the write side keeps its narrow width.
- R8: While an output valid is high and its ready is low, the valid stays high and the data stays stable. No word is lost or duplicated under back-pressure.
- R9: wr_fill_lanes gives the number of 9-bit lanes collected in the unfinished write word. rd_fill_lanes gives the number of lanes of the current read-side storage word that have not yet been read, and is 0 when none is held.
- R10: A cycle with part_rst high discards any partial or pending word on both sides. The next write word starts a fresh storage word, and the next read starts from the first sub-word of a newly fetched word.
- R11: After reset, wr_ready and st_rd_ready are high, st_wr_valid and rd_valid are low, and both fill counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset, released synchronously inside the block |
| part_rst | input | 1 | Synchronous active-high partial reset |
| cfg_in_w | input | 2 | Write-side width code |
| cfg_out_w | input | 2 | Read-side width code |
| cfg_big_end | input | 1 | 1 = big-endian sub-word order, 0 = little-endian |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word accepted this cycle when valid |
| wr_data | input | 36 | Write word, narrow widths in the low bits |
| st_wr_valid | output | 1 | Assembled storage word offered |
| st_wr_ready | input | 1 | Storage accepts the word |
| st_wr_data | output | 36 | Assembled storage word |
| st_rd_valid | input | 1 | Storage word offered for reading |
| st_rd_ready | output | 1 | Block takes the storage word |
| st_rd_data | input | 36 | Storage word to split |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Reader takes the word |
| rd_data | output | 36 | Read word, narrow widths in the low bits |
| wr_fill_lanes | output | 3 | Lanes collected in the unfinished write word |
| rd_fill_lanes | output | 3 | Lanes still to be read from the held storage word |

## Verification
The bench builds the block with its default parameters: 9-bit lanes, four lanes per storage word. This keeps the space of configurations small enough to sweep in full.

The sweep covers all sixteen pairs of width codes in both byte orders. That includes the reserved code and the illegal narrow-to-narrow pairs, so every legal pairing is run, and so is every remapping. Storage and read back-pressure follow fixed cyclic patterns, which makes stalls occur at every sub-word position.

Directed sequences then check three things: that configuration changes after reset are ignored, that the fill counts read correctly in mid-word, and that partial reset discards partial words on both sides.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  // Width selection for one side of the converter
  typedef enum logic [1:0] {
    BW_X36  = 2'd0,
    BW_X18  = 2'd1,
    BW_X9   = 2'd2,
    BW_RSVD = 2'd3
  } bus_w_e;

  // Number of lanes moved per narrow-side transfer
  function automatic int unsigned xfer_lanes(input bus_w_e w, input int unsigned lanes);
    case (w)
      BW_X18:  return lanes / 2;
      BW_X9:   return 1;
      default: return lanes;
    endcase
  endfunction

endpackage

// File: rtl/bmc_packer.sv
module bmc_packer
  import bmc_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned CW     = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              part_rst,
  input  bus_w_e            in_w,
  input  logic              big_end,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [WORD_W-1:0] st_data,
  output logic [CW-1:0]     fill_lanes
);

  logic [WORD_W-1:0] asm_q, asm_d;
  logic [CW-1:0]     idx_q, idx_d;
  logic              full_q, full_d;
  logic              asm_en, wr_fire;
  int unsigned       kw, m, cur, slot;

  always_comb begin
    kw   = xfer_lanes(in_w, LANES);
    m    = LANES / kw;
    cur  = 32'(idx_q);
    slot = big_end ? (m - 1 - cur) : cur;

    wr_ready = (!full_q || st_ready) && !part_rst;
    st_valid = full_q && !part_rst;
    st_data  = asm_q;
    wr_fire  = wr_valid && wr_ready;

    // Steer the incoming narrow word into its lane group
    asm_d = asm_q;
    for (int unsigned l = 0; l < LANES; l++) begin
      if (l >= slot * kw && l < slot * kw + kw)
        asm_d[l*LANE_W +: LANE_W] = wr_data[(l - slot*kw)*LANE_W +: LANE_W];
    end
    asm_en = wr_fire;

    full_d = full_q;
    idx_d  = idx_q;
    if (full_q && st_ready) full_d = 1'b0;
    if (wr_fire) begin
      if (cur == m - 1) begin
        idx_d  = '0;
        full_d = 1'b1;
      end else begin
        idx_d = idx_q + CW'(1);
      end
    end
    if (part_rst) begin
      idx_d  = '0;
      full_d = 1'b0;
    end

    fill_lanes = CW'(cur * kw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (asm_en) asm_q <= asm_d;
  end

endmodule

// File: rtl/bmc_unpacker.sv
module bmc_unpacker
  import bmc_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned CW     = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              part_rst,
  input  bus_w_e            out_w,
  input  logic              big_end,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [WORD_W-1:0] st_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic [CW-1:0]     left_lanes
);

  logic [WORD_W-1:0] hold_q;
  logic [CW-1:0]     idx_q, idx_d;
  logic              have_q, have_d;
  logic              hold_en, rd_fire, st_fire, last;
  int unsigned       kw, m, cur, slot;

  always_comb begin
    kw   = xfer_lanes(out_w, LANES);
    m    = LANES / kw;
    cur  = 32'(idx_q);
    slot = big_end ? (m - 1 - cur) : cur;
    last = (cur == m - 1);

    rd_valid = have_q && !part_rst;
    rd_fire  = rd_valid && rd_ready;
    st_ready = (!have_q || (rd_fire && last)) && !part_rst;
    st_fire  = st_valid && st_ready;

    // Select the current lane group into the low bits, zero above
    rd_data = '0;
    for (int unsigned l = 0; l < LANES; l++) begin
      if (l < kw)
        rd_data[l*LANE_W +: LANE_W] = hold_q[(slot*kw + l)*LANE_W +: LANE_W];
    end

    have_d = have_q;
    idx_d  = idx_q;
    if (rd_fire) begin
      if (last) begin
        have_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + CW'(1);
      end
    end
    if (st_fire) have_d = 1'b1;
    if (part_rst) begin
      have_d = 1'b0;
      idx_d  = '0;
    end
    hold_en = st_fire;

    left_lanes = have_q ? CW'((m - cur) * kw) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      have_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      have_q <= have_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_en) hold_q <= st_data;
  end

endmodule

// File: rtl/bus_match_conv.sv
module bus_match_conv
  import bmc_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned CW     = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              part_rst,
  input  logic [1:0]        cfg_in_w,
  input  logic [1:0]        cfg_out_w,
  input  logic              cfg_big_end,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  output logic              st_wr_valid,
  input  logic              st_wr_ready,
  output logic [WORD_W-1:0] st_wr_data,
  input  logic              st_rd_valid,
  output logic              st_rd_ready,
  input  logic [WORD_W-1:0] st_rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic [CW-1:0]     wr_fill_lanes,
  output logic [CW-1:0]     rd_fill_lanes
);

  logic [1:0] rsync_q;
  logic       rst_sn;
  logic       run_q;
  bus_w_e     in_eff, out_eff, in_w_q, out_w_q;
  logic       be_q;

  // Reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  // Map reserved codes and illegal narrow-to-narrow pairs
  always_comb begin
    in_eff  = (cfg_in_w  == 2'd3) ? BW_X36 : bus_w_e'(cfg_in_w);
    out_eff = (cfg_out_w == 2'd3) ? BW_X36 : bus_w_e'(cfg_out_w);
    if (in_eff != BW_X36 && out_eff != BW_X36) out_eff = BW_X36;
  end

  // Configuration is captured only until the block starts running
  always_ff @(posedge clk) begin
    if (!run_q) begin
      in_w_q  <= in_eff;
      out_w_q <= out_eff;
      be_q    <= cfg_big_end;
    end
  end

  bmc_packer #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
    .clk        (clk),
    .rst_n      (rst_sn),
    .part_rst   (part_rst),
    .in_w       (in_w_q),
    .big_end    (be_q),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_data    (wr_data),
    .st_valid   (st_wr_valid),
    .st_ready   (st_wr_ready),
    .st_data    (st_wr_data),
    .fill_lanes (wr_fill_lanes)
  );

  bmc_unpacker #(.LANE_W(LANE_W), .LANES(LANES)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_sn),
    .part_rst   (part_rst),
    .out_w      (out_w_q),
    .big_end    (be_q),
    .st_valid   (st_rd_valid),
    .st_ready   (st_rd_ready),
    .st_data    (st_rd_data),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .left_lanes (rd_fill_lanes)
  );

endmodule

// File: rtl/bmc_chk.sv
module bmc_chk
  import bmc_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned CW     = $clog2(LANES + 1)
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              part_rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              st_wr_valid,
  input logic              st_wr_ready,
  input logic [WORD_W-1:0] st_wr_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [WORD_W-1:0] rd_data,
  input bus_w_e            out_w,
  input logic [CW-1:0]     wr_fill_lanes,
  input logic [CW-1:0]     rd_fill_lanes
);

  // R8
  st_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn || part_rst)
    st_wr_valid && !st_wr_ready |=> st_wr_valid && $stable(st_wr_data));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn || part_rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R3
  pack_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(st_wr_valid) |-> $past(wr_valid && wr_ready));

  // R10
  prst_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    part_rst |=> (wr_fill_lanes == '0) && (rd_fill_lanes == '0) && !st_wr_valid && !rd_valid);

  // R4
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_valid && (out_w == BW_X9) |-> (rd_data[WORD_W-1:LANE_W] == '0));

  // R9
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    32'(wr_fill_lanes) < LANES);

endmodule

bind bus_match_conv bmc_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk           (clk),
  .rst_sn        (rst_sn),
  .part_rst      (part_rst),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .st_wr_valid   (st_wr_valid),
  .st_wr_ready   (st_wr_ready),
  .st_wr_data    (st_wr_data),
  .rd_valid      (rd_valid),
  .rd_ready      (rd_ready),
  .rd_data       (rd_data),
  .out_w         (out_w_q),
  .wr_fill_lanes (wr_fill_lanes),
  .rd_fill_lanes (rd_fill_lanes)
);

// File: tb/sim_bus_match_conv.sv
module sim_bus_match_conv;

  localparam int NWORDS = 6;

  logic        clk = 1'b0;
  logic        rst_n, part_rst;
  logic [1:0]  cfg_in_w, cfg_out_w;
  logic        cfg_big_end;
  logic        wr_valid, wr_ready;
  logic [35:0] wr_data;
  logic        st_wr_valid, st_wr_ready;
  logic [35:0] st_wr_data;
  logic        st_rd_valid, st_rd_ready;
  logic [35:0] st_rd_data;
  logic        rd_valid, rd_ready;
  logic [35:0] rd_data;
  logic [2:0]  wr_fill_lanes, rd_fill_lanes;

  logic bp_on = 1'b0, bp_st = 1'b1, bp_rd = 1'b1, man_st = 1'b1, man_rd = 1'b1;
  int   cyc = 0;
  int   checks = 0, fails = 0;
  logic [35:0] got_st[$], got_rd[$], exp_st[$], exp_rd[$];

  always #4 clk = ~clk;

  assign st_wr_ready = bp_on ? bp_st : man_st;
  assign rd_ready    = bp_on ? bp_rd : man_rd;

  bus_match_conv u0 (
    .clk(clk), .rst_n(rst_n), .part_rst(part_rst),
    .cfg_in_w(cfg_in_w), .cfg_out_w(cfg_out_w), .cfg_big_end(cfg_big_end),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .st_wr_valid(st_wr_valid), .st_wr_ready(st_wr_ready), .st_wr_data(st_wr_data),
    .st_rd_valid(st_rd_valid), .st_rd_ready(st_rd_ready), .st_rd_data(st_rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_fill_lanes(wr_fill_lanes), .rd_fill_lanes(rd_fill_lanes)
  );

  // Back-pressure patterns, updated away from the active edge
  always @(negedge clk) begin
    cyc++;
    bp_st = (cyc % 5) != 2;
    bp_rd = (cyc % 3) != 1;
  end

  // Transfer monitor, sampled shortly before each rising edge
  always begin
    @(negedge clk);
    #3.5;
    if (st_wr_valid && st_wr_ready) got_st.push_back(st_wr_data);
    if (rd_valid && rd_ready)       got_rd.push_back(rd_data);
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    report();
    $finish;
  end

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int kw_of(input int code);
    return (code == 1) ? 2 : (code == 2) ? 1 : 4;
  endfunction

  function automatic logic [35:0] mkword(input int c, input int w);
    logic [35:0] r;
    for (int l = 0; l < 4; l++) r[l*9 +: 9] = 9'((c*53 + w*17 + l*101 + 7) % 512);
    return r;
  endfunction

  function automatic logic [35:0] subword(input logic [35:0] w, input int kw, input int slot);
    logic [35:0] mask;
    mask = (36'h1 << (kw*9)) - 36'h1;
    return (w >> (slot*kw*9)) & mask;
  endfunction

  task automatic send_w(input logic [35:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    #3;
    while (!wr_ready) begin @(negedge clk); #3; end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic send_s(input logic [35:0] d);
    @(negedge clk);
    st_rd_valid = 1'b1; st_rd_data = d;
    #3;
    while (!st_rd_ready) begin @(negedge clk); #3; end
    @(negedge clk);
    st_rd_valid = 1'b0;
  endtask

  task automatic pulse_prst();
    @(negedge clk); part_rst = 1'b1;
    @(negedge clk); part_rst = 1'b0;
    #3;
  endtask

  task automatic do_reset(input int ci, input int co, input bit be);
    @(negedge clk);
    rst_n = 1'b0; part_rst = 1'b0;
    wr_valid = 1'b0; st_rd_valid = 1'b0; wr_data = '0; st_rd_data = '0;
    cfg_in_w = 2'(ci); cfg_out_w = 2'(co); cfg_big_end = be;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    // R11 reset state
    chk("R11 reset state",
        36'({wr_ready, st_wr_valid, rd_valid, st_rd_ready, wr_fill_lanes, rd_fill_lanes}),
        36'({1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 3'd0}));
  endtask

  initial begin
    int cfgn;
    logic [35:0] w0, n0, n1, n2, n3;
    rst_n = 1'b0; part_rst = 1'b0; wr_valid = 1'b0; st_rd_valid = 1'b0;
    wr_data = '0; st_rd_data = '0;
    cfg_in_w = 2'd0; cfg_out_w = 2'd0; cfg_big_end = 1'b0;
    cfgn = 0;

    // Sweep every code pair and both byte orders
    for (int ci = 0; ci < 4; ci++) begin
      for (int co = 0; co < 4; co++) begin
        for (int be = 0; be < 2; be++) begin
          int ei, eo, kin, kout, mi, mo;
          string wtag, rtag;
          ei = (ci == 3) ? 0 : ci;
          eo = (co == 3) ? 0 : co;
          if (ei != 0 && eo != 0) eo = 0;
          kin = kw_of(ei); kout = kw_of(eo);
          mi = 4 / kin;    mo = 4 / kout;
          wtag = (ei == 0) ? "R2 write" : (be != 0) ? "R3/R5 write" : "R3/R6 write";
          if (eo != 0)              rtag = (be != 0) ? "R4/R5 read" : "R4/R6 read";
          else if (ci != 0 && ci != 3 && co != 0 && co != 3) rtag = "R7 read";
          else                      rtag = "R2 read";

          do_reset(ci, co, be[0]);
          got_st.delete(); got_rd.delete(); exp_st.delete(); exp_rd.delete();
          bp_on = 1'b1;
          fork
            begin
              for (int w = 0; w < NWORDS; w++) begin
                logic [35:0] word;
                word = mkword(cfgn, w);
                exp_st.push_back(word);
                for (int i = 0; i < mi; i++)
                  send_w(subword(word, kin, (be != 0) ? (mi - 1 - i) : i));
              end
            end
            begin
              for (int w = 0; w < NWORDS; w++) begin
                logic [35:0] word;
                word = mkword(cfgn + 100, w);
                for (int j = 0; j < mo; j++)
                  exp_rd.push_back(subword(word, kout, (be != 0) ? (mo - 1 - j) : j));
                send_s(word);
              end
            end
          join
          repeat (16) @(negedge clk);
          bp_on = 1'b0;

          chk({wtag, " count"}, 36'(got_st.size()), 36'(exp_st.size()));
          for (int k = 0; k < exp_st.size() && k < got_st.size(); k++)
            chk(wtag, got_st[k], exp_st[k]);
          chk({rtag, " count"}, 36'(got_rd.size()), 36'(exp_rd.size()));
          for (int k = 0; k < exp_rd.size() && k < got_rd.size(); k++)
            chk(rtag, got_rd[k], exp_rd[k]);
          cfgn++;
        end
      end
    end

    // R1: configuration changes after reset are ignored
    man_st = 1'b1; man_rd = 1'b1;
    do_reset(2, 0, 1'b1);
    cfg_in_w = 2'd0; cfg_out_w = 2'd2; cfg_big_end = 1'b0;
    got_st.delete(); got_rd.delete();
    n0 = 36'h1AB; n1 = 36'h0C3; n2 = 36'h15A; n3 = 36'h027;
    send_w(n0);
    chk("R1 width kept after reset", 36'({st_wr_valid, wr_fill_lanes}), 36'({1'b0, 3'd1}));
    send_w(n1); send_w(n2); send_w(n3);
    repeat (3) @(negedge clk);
    chk("R1 order kept count", 36'(got_st.size()), 36'd1);
    if (got_st.size() > 0)
      chk("R1 order kept", got_st[0], {n0[8:0], n1[8:0], n2[8:0], n3[8:0]});
    w0 = 36'h9_8765_4321;
    send_s(w0);
    repeat (3) @(negedge clk);
    chk("R1 read width kept count", 36'(got_rd.size()), 36'd1);
    if (got_rd.size() > 0) chk("R1 read width kept", got_rd[0], w0);

    // R9, R10: write-side fill count and partial discard
    send_w(36'h111); send_w(36'h022);
    #3;
    chk("R9 write fill after two", 36'(wr_fill_lanes), 36'd2);
    pulse_prst();
    chk("R10 write partial cleared", 36'({st_wr_valid, wr_fill_lanes}), 36'd0);
    got_st.delete();
    send_w(n3); send_w(n2); send_w(n1); send_w(n0);
    repeat (3) @(negedge clk);
    chk("R10 fresh word count", 36'(got_st.size()), 36'd1);
    if (got_st.size() > 0)
      chk("R10 fresh word", got_st[0], {n3[8:0], n2[8:0], n1[8:0], n0[8:0]});

    // R9, R10: read-side fill count and partial discard (x36 to x9, little-endian)
    do_reset(0, 2, 1'b0);
    man_rd = 1'b0;
    send_s(w0);
    #3;
    chk("R9/R6 first read lane", rd_data, {27'd0, w0[8:0]});
    chk("R9 read fill full", 36'(rd_fill_lanes), 36'd4);
    @(negedge clk); man_rd = 1'b1;
    @(negedge clk); man_rd = 1'b0;
    #3;
    chk("R6 second read lane", rd_data, {27'd0, w0[17:9]});
    chk("R9 read fill after one", 36'(rd_fill_lanes), 36'd3);
    pulse_prst();
    chk("R10 read partial cleared", 36'({rd_valid, st_rd_ready, rd_fill_lanes}), 36'({1'b0, 1'b1, 3'd0}));
    got_rd.delete();
    man_rd = 1'b1;
    send_s(36'hA_BCDE_F012);
    repeat (6) @(negedge clk);
    chk("R10 read restart count", 36'(got_rd.size()), 36'd4);
    if (got_rd.size() > 0) chk("R10 read restart first", got_rd[0], 36'h012);

    report();
    $finish;
  end

endmodule